// File: doc/BRIEF.md
# Command-Response Buffer Control Register Block

This block is the host-visible control and status window of a security coprocessor that exchanges commands and responses through a shared buffer. A host bus writes 32-bit registers and reads them at any byte offset. Writes to the request, start, cancel and locality registers have side effects. A command engine behind the block receives a one-cycle request pulse when a command is started, a one-cycle cancel pulse, and returns a done pulse with an error flag.

The register file also holds identification and capability constants and the buffer address and size words. All of these are fixed at reset from parameters. The block also derives two lengths from engine inputs. The first is the usable buffer length, which is the smaller of the engine capacity and the data buffer size. The second is the command input length, which is the smaller of the header-declared size and the usable buffer length.

Top module: `crb_regs_top`

## Requirements
- R1: A write to the request register (byte 0x10) of exactly 1 clears the idle flag, which is bit 1 of the status register (0x14). A write of exactly 2 sets that flag. Any other value leaves it unchanged. After reset the idle flag is 0.
- R2: A write of exactly 1 to the start register (0x1C) is accepted only while start bit 0 reads 0. On acceptance, start bit 0 becomes 1 and `reqPulse` is high for exactly one cycle. Any other write to this register is ignored.
- R3: A write of exactly 1 to the cancel register (0x18) drives `cancelPulse` high for one cycle, but only while the start bit is 1. Any other case produces no pulse.
- R4: A `doneIn` pulse while the start bit is 1 clears the start bit. If `doneErr` is also high, it sets the fatal bit, which is bit 0 of the status register, and that bit stays set until reset. A `doneIn` pulse while the start bit is 0 has no effect.
- R5: A write of exactly 1 to the locality-control register (0x08) sets granted (bit 0) and clears seized (bit 1) in locality status (0x04). It also sets assigned (bit 1) in locality state (0x00). Writes of 2 or 8 change nothing.
- R6: A read at byte address A returns the 32-bit word at A with its low two bits cleared, shifted right by 8×A[1:0] bits.
- R7: After reset, locality state reads 0x1 (register-valid in bit 0). The identification word (0x0C) reads 0x6C11. Its fields are: type in [3:0] = 1, version in [7:4] = 1, locality-0-only in [8] = 0, idle bypass in [9] = 0, transfer size in [11:10] = 3, FIFO in [12] = 0, buffer capability in [13] = 1, selector in [15:14] = 1, revision in [19:16] = 0.
- R8: After reset, the command size (0x20) and response size (0x28) registers both read the region size minus the data offset (default 0xF80). The command address (0x24) and response address (0x2C) registers both read the base address plus the data offset (default 0xFED40080).
- R9: `effLen` equals the smaller of `engCapacity` and the buffer size. `inLen` equals the smaller of `hdrLen` and `effLen`.
- R10: Writes to registers without a side effect, such as the identification and address registers, are ignored. Reset clears the start bit, the fatal bit and the granted flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host write strobe |
| wrAddr | input | ADDR_W | Host write byte address |
| wrData | input | 32 | Host write data |
| rdAddr | input | ADDR_W | Host read byte address |
| rdData | output | 32 | Shifted read data, combinational |
| reqPulse | output | 1 | One-cycle command request to the engine |
| cancelPulse | output | 1 | One-cycle cancel request to the engine |
| doneIn | input | 1 | Engine completion pulse |
| doneErr | input | 1 | Error flag qualifying `doneIn` |
| engCapacity | input | LEN_W | Engine buffer capacity |
| hdrLen | input | LEN_W | Size declared in the command header |
| effLen | output | LEN_W | Usable buffer length |
| inLen | output | LEN_W | Command input length |

## Verification
A corrupted start bit shows up at once at the engine side. A stuck bit either repeats or loses `reqPulse`, or makes a cancel write wrongly produce or drop a pulse. Either way it is visible one cycle after the host write. A status or locality flag that flips wrongly is visible on the next read of its word. Byte-offset reads of the constant words expose any error in the shift in the same cycle.

// File: rtl/crb_pkg.sv
package crb_pkg;
  // word indices (byte address >> 2)
  localparam int IDX_LOC_STATE = 0;
  localparam int IDX_LOC_STS   = 1;
  localparam int IDX_LOC_CTRL  = 2;
  localparam int IDX_IDENT     = 3;
  localparam int IDX_REQ       = 4;
  localparam int IDX_STATUS    = 5;
  localparam int IDX_CANCEL    = 6;
  localparam int IDX_START     = 7;
  localparam int IDX_CMD_SIZE  = 8;
  localparam int IDX_CMD_ADDR  = 9;
  localparam int IDX_RSP_SIZE  = 10;
  localparam int IDX_RSP_ADDR  = 11;

  // identification field values
  localparam logic [3:0] ID_TYPE     = 4'd1;
  localparam logic [3:0] ID_VERSION  = 4'd1;
  localparam logic       ID_LOC0     = 1'b0;
  localparam logic       ID_BYPASS   = 1'b0;
  localparam logic [1:0] ID_XFER     = 2'b11;
  localparam logic       ID_FIFO     = 1'b0;
  localparam logic       ID_BUFCAP   = 1'b1;
  localparam logic [1:0] ID_SELECT   = 2'd1;
  localparam logic [3:0] ID_REV      = 4'd0;

  typedef struct packed {
    logic setReady;
    logic setIdle;
    logic setStart;
    logic clrStart;
    logic setFatal;
    logic grantLoc;
  } ctlStrobes_t;
endpackage

// File: rtl/crbCtrl.sv
module crbCtrl
  import crb_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic              startQ,
  input  logic              doneIn,
  input  logic              doneErr,
  output ctlStrobes_t       strb,
  output logic              reqPulse,
  output logic              cancelPulse
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic hitReq, hitStart, hitCancel, hitLoc, cancelGo;

  assign wordIdx = wrAddr[ADDR_W-1:2];

  always_comb begin
    hitReq    = wrEn && (wordIdx == IDX_W'(IDX_REQ));
    hitStart  = wrEn && (wordIdx == IDX_W'(IDX_START));
    hitCancel = wrEn && (wordIdx == IDX_W'(IDX_CANCEL));
    hitLoc    = wrEn && (wordIdx == IDX_W'(IDX_LOC_CTRL));

    strb.setReady = hitReq && (wrData == 32'd1);
    strb.setIdle  = hitReq && (wrData == 32'd2);
    strb.setStart = hitStart && (wrData == 32'd1) && !startQ;
    strb.clrStart = doneIn && startQ;
    strb.setFatal = doneIn && startQ && doneErr;
    strb.grantLoc = hitLoc && (wrData == 32'd1);
    cancelGo      = hitCancel && (wrData == 32'd1) && startQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqPulse    <= 1'b0;
      cancelPulse <= 1'b0;
    end else begin
      reqPulse    <= strb.setStart;
      cancelPulse <= cancelGo;
    end
  end

  // R2: request is a single-cycle pulse and coincides with start bit set
  p_req_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqPulse |=> !reqPulse);
  p_req_with_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqPulse |-> startQ);
  // R3: cancel only when start was set at the write
  p_cancel_needs_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    cancelPulse |-> $past(startQ));
endmodule

// File: rtl/crbRegs.sv
module crbRegs
  import crb_pkg::*;
#(
  parameter int          ADDR_W      = 6,
  parameter int          LEN_W       = 16,
  parameter int          REGION_SIZE = 4096,
  parameter int          DATA_OFS    = 128,
  parameter logic [31:0] BASE_ADDR   = 32'hFED4_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [31:0]       rdData,
  output logic              startQ,
  input  logic [LEN_W-1:0]  engCapacity,
  input  logic [LEN_W-1:0]  hdrLen,
  output logic [LEN_W-1:0]  effLen,
  output logic [LEN_W-1:0]  inLen
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [31:0] BUF_SIZE = 32'(REGION_SIZE - DATA_OFS);
  localparam logic [31:0] BUF_ADDR = BASE_ADDR + 32'(DATA_OFS);
  localparam logic [LEN_W-1:0] BUF_LEN = LEN_W'(REGION_SIZE - DATA_OFS);
  localparam logic [31:0] IDENT_WORD = {12'd0, ID_REV, ID_SELECT, ID_BUFCAP,
    ID_FIFO, ID_XFER, ID_BYPASS, ID_LOC0, ID_VERSION, ID_TYPE};

  logic idleQ, fatalQ, grantedQ, seizedQ, assignedQ, validQ;
  logic [31:0] word;
  logic [IDX_W-1:0] rdIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleQ     <= 1'b0;
      fatalQ    <= 1'b0;
      startQ    <= 1'b0;
      grantedQ  <= 1'b0;
      seizedQ   <= 1'b0;
      assignedQ <= 1'b0;
      validQ    <= 1'b1;
    end else begin
      if (strb.setReady) idleQ <= 1'b0;
      else if (strb.setIdle) idleQ <= 1'b1;
      if (strb.setStart) startQ <= 1'b1;
      else if (strb.clrStart) startQ <= 1'b0;
      if (strb.setFatal) fatalQ <= 1'b1;
      if (strb.grantLoc) begin
        grantedQ  <= 1'b1;
        seizedQ   <= 1'b0;
        assignedQ <= 1'b1;
      end
    end
  end

  assign rdIdx = rdAddr[ADDR_W-1:2];

  always_comb begin
    word = 32'd0;
    case (rdIdx)
      IDX_W'(IDX_LOC_STATE): word = {30'd0, assignedQ, validQ};
      IDX_W'(IDX_LOC_STS):   word = {30'd0, seizedQ, grantedQ};
      IDX_W'(IDX_IDENT):     word = IDENT_WORD;
      IDX_W'(IDX_STATUS):    word = {30'd0, idleQ, fatalQ};
      IDX_W'(IDX_START):     word = {31'd0, startQ};
      IDX_W'(IDX_CMD_SIZE):  word = BUF_SIZE;
      IDX_W'(IDX_CMD_ADDR):  word = BUF_ADDR;
      IDX_W'(IDX_RSP_SIZE):  word = BUF_SIZE;
      IDX_W'(IDX_RSP_ADDR):  word = BUF_ADDR;
      default:               word = 32'd0;
    endcase
    rdData = word >> {rdAddr[1:0], 3'b000};
  end

  always_comb begin
    effLen = (engCapacity < BUF_LEN) ? engCapacity : BUF_LEN;
    inLen  = (hdrLen < effLen) ? hdrLen : effLen;
  end

  // R4: completion clears start; fatal is sticky
  p_done_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrStart |=> !startQ);
  p_fatal_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    fatalQ |=> fatalQ);
  // R5: grant and seized never both set
  p_grant_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    grantedQ |-> !seizedQ);
  // R9: derived lengths within bounds
  p_len_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    (effLen <= BUF_LEN) && (inLen <= effLen));
endmodule

// File: rtl/crb_regs_top.sv
module crb_regs_top
  import crb_pkg::*;
#(
  parameter int          ADDR_W      = 6,
  parameter int          LEN_W       = 16,
  parameter int          REGION_SIZE = 4096,
  parameter int          DATA_OFS    = 128,
  parameter logic [31:0] BASE_ADDR   = 32'hFED4_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [31:0]       rdData,
  output logic              reqPulse,
  output logic              cancelPulse,
  input  logic              doneIn,
  input  logic              doneErr,
  input  logic [LEN_W-1:0]  engCapacity,
  input  logic [LEN_W-1:0]  hdrLen,
  output logic [LEN_W-1:0]  effLen,
  output logic [LEN_W-1:0]  inLen
);
  ctlStrobes_t strb;
  logic startQ;

  crbCtrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .startQ(startQ), .doneIn(doneIn), .doneErr(doneErr), .strb(strb),
    .reqPulse(reqPulse), .cancelPulse(cancelPulse)
  );

  crbRegs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .REGION_SIZE(REGION_SIZE),
            .DATA_OFS(DATA_OFS), .BASE_ADDR(BASE_ADDR)) regs_i (
    .clk(clk), .rstN(rstN), .strb(strb), .rdAddr(rdAddr), .rdData(rdData),
    .startQ(startQ), .engCapacity(engCapacity), .hdrLen(hdrLen),
    .effLen(effLen), .inLen(inLen)
  );
endmodule

// File: tb/crb_regs_top_tb_top.sv
module crb_regs_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [5:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [5:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        reqPulse, cancelPulse;
  logic        doneIn = 1'b0, doneErr = 1'b0;
  logic [15:0] engCapacity = 16'd4096, hdrLen = 16'd0;
  logic [15:0] effLen, inLen;

  int total = 0, bad = 0, reqCnt = 0, cancelCnt = 0, cyc = 0;

  always #4 clk = ~clk;

  crb_regs_top dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .reqPulse(reqPulse),
    .cancelPulse(cancelPulse), .doneIn(doneIn), .doneErr(doneErr),
    .engCapacity(engCapacity), .hdrLen(hdrLen), .effLen(effLen), .inLen(inLen)
  );

  always @(negedge clk) begin
    cyc++;
    if (reqPulse) reqCnt++;
    if (cancelPulse) cancelCnt++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic rdChk(input string req, input logic [5:0] a, input logic [31:0] exp);
    rdAddr = a; #1;
    check(req, rdData, exp);
  endtask

  task automatic done(input logic e);
    @(negedge clk); doneIn = 1'b1; doneErr = e;
    @(negedge clk); doneIn = 1'b0; doneErr = 1'b0;
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic testReset();
    rdChk("R7 locstate", 6'h00, 32'h1);
    rdChk("R7 ident", 6'h0C, 32'h6C11);
    rdChk("R8 cmdsize", 6'h20, 32'hF80);
    rdChk("R8 cmdaddr", 6'h24, 32'hFED40080);
    rdChk("R8 rspsize", 6'h28, 32'hF80);
    rdChk("R8 rspaddr", 6'h2C, 32'hFED40080);
    rdChk("R10 start clr", 6'h1C, 32'h0);
    rdChk("R10 status clr", 6'h14, 32'h0);
    rdChk("R10 granted clr", 6'h04, 32'h0);
  endtask

  task automatic testIdle();
    wr(6'h10, 32'd2); rdChk("R1 go idle", 6'h14, 32'h2);
    wr(6'h10, 32'd3); rdChk("R1 other value", 6'h14, 32'h2);
    wr(6'h10, 32'd1); rdChk("R1 ready", 6'h14, 32'h0);
  endtask

  task automatic testStartCancel();
    wr(6'h1C, 32'd3); rdChk("R2 bad value", 6'h1C, 32'h0);
    check("R2 no pulse", 32'(reqCnt), 32'd0);
    wr(6'h18, 32'd1); check("R3 cancel idle", 32'(cancelCnt), 32'd0);
    wr(6'h1C, 32'd1); rdChk("R2 start set", 6'h1C, 32'h1);
    check("R2 one pulse", 32'(reqCnt), 32'd1);
    wr(6'h1C, 32'd1); check("R2 busy reject", 32'(reqCnt), 32'd1);
    wr(6'h18, 32'd2); check("R3 cancel bad value", 32'(cancelCnt), 32'd0);
    wr(6'h18, 32'd1); check("R3 cancel busy", 32'(cancelCnt), 32'd1);
  endtask

  task automatic testDone();
    done(1'b0); rdChk("R4 start clr", 6'h1C, 32'h0);
    rdChk("R4 no fatal", 6'h14, 32'h0);
    done(1'b1); rdChk("R4 stray done", 6'h14, 32'h0);
    wr(6'h18, 32'd1); check("R3 cancel after done", 32'(cancelCnt), 32'd1);
    wr(6'h1C, 32'd1); check("R2 restart", 32'(reqCnt), 32'd2);
    done(1'b1); rdChk("R4 fatal set", 6'h14, 32'h1);
    rdChk("R4 start clr err", 6'h1C, 32'h0);
    wr(6'h10, 32'd1); rdChk("R4 fatal sticky", 6'h14, 32'h1);
  endtask

  task automatic testLocality();
    wr(6'h08, 32'd2); rdChk("R5 relinquish", 6'h04, 32'h0);
    wr(6'h08, 32'd8); rdChk("R5 reset-est", 6'h00, 32'h1);
    wr(6'h08, 32'd1); rdChk("R5 granted", 6'h04, 32'h1);
    rdChk("R5 assigned", 6'h00, 32'h3);
  endtask

  task automatic testBytes();
    rdChk("R6 ident b1", 6'h0D, 32'h6C);
    rdChk("R6 ident b2", 6'h0E, 32'h0);
    rdChk("R6 addr b3", 6'h27, 32'hFE);
    rdChk("R6 addr b1", 6'h25, 32'hFED400);
  endtask

  task automatic testIgnored();
    wr(6'h0C, 32'hFFFF_FFFF); rdChk("R10 ident ro", 6'h0C, 32'h6C11);
    wr(6'h24, 32'h0);         rdChk("R10 addr ro", 6'h24, 32'hFED40080);
    wr(6'h20, 32'h1);         rdChk("R10 size ro", 6'h20, 32'hF80);
  endtask

  task automatic testLens();
    engCapacity = 16'd4096; hdrLen = 16'd5000; #1;
    check("R9 eff cap", 32'(effLen), 32'd3968);
    check("R9 in cap", 32'(inLen), 32'd3968);
    engCapacity = 16'd1024; hdrLen = 16'd300; #1;
    check("R9 eff small", 32'(effLen), 32'd1024);
    check("R9 in hdr", 32'(inLen), 32'd300);
    hdrLen = 16'd2000; #1;
    check("R9 in eff", 32'(inLen), 32'd1024);
  endtask

  initial begin
    doReset();
    testReset();
    testIdle();
    testStartCancel();
    testDone();
    testLocality();
    testBytes();
    testIgnored();
    testLens();
    wr(6'h1C, 32'd1);
    doReset();
    testReset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=<20000", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule